// File: doc/BRIEF.md
# Paged ROM Bank Select Decoder

This block decodes a 16-bit byte address into a 64K-byte read-only space made of eight banks of 8K bytes each. Its outputs are one active-low chip-select line and one active-low output-enable line for each bank, plus the 13-bit offset inside the bank. A small behavioural bank model and a read-data mux stand behind the decoder. Together they return the byte that the enabled bank would place on the shared data bus, so the decode can be checked end to end.

Two decode variants can be chosen with a parameter. In paired mode, a 2-to-4 decoder on the top two address bits asserts chip select on a pair of banks at once. Address bit 13 then output-enables only the even or the odd member of that pair. In full mode, a 3-to-8 decoder on bits 15 to 13 selects a single bank, and its output-enable line is tied to its chip-select line. In both modes the bank that drives the bus is the one numbered by address bits 15 to 13.

Top module: `rom_page_decode`

## Requirements
- R1: `bank_addr` always equals address bits 12 down to 0.
- R2: In paired mode, `cs_n` is low on exactly two banks, numbers 2g and 2g+1, where g is address bits 15:14. It is high on all other banks.
- R3: In paired mode, `oe_n` of every even-numbered bank equals address bit 13, and `oe_n` of every odd-numbered bank equals its complement. This holds whatever the chip-select state is.
- R4: In full mode, `cs_n` is low only on the bank numbered by address bits 15:13, and `oe_n` equals `cs_n` bit for bit.
- R5: In either mode, exactly one bank has both `cs_n` and `oe_n` low, and it is the bank numbered by address bits 15:13.
- R6: `rd_data` is the content of the enabled bank at the in-bank offset. The content of bank b at offset o is (3*o + 85*b + floor(o/256)) mod 256.
- R7: For every one of the 65536 addresses, paired mode and full mode return the same `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Byte address into the 64K space |
| cs_n | output | 8 | Active-low chip select, one bit per bank (bit i = bank i) |
| oe_n | output | 8 | Active-low output enable, one bit per bank |
| bank_addr | output | 13 | Offset within the selected bank |
| rd_data | output | 8 | Byte returned by the bank that both selects and enables |

## Verification
The bench builds two copies side by side, both with the default geometry of 16 address bits and 13 bank bits. One uses the paired 2-to-4 mode and the other the full 3-to-8 mode. This allows the two modes to be compared address by address. The sweep covers all 65536 addresses, so every pair boundary, every even/odd split and every bank's last byte is reached. Seeded random addresses and directed edges at the bank boundaries come before the sweep.

// File: rtl/rom_page_pkg.sv
package rom_page_pkg;
   typedef enum logic {
      SEL_FULL   = 1'b0,
      SEL_PAIRED = 1'b1
   } sel_mode_e;

   // Behavioural bank content: word = MULT*offset + BANK_STEP*bank + (offset >> HI_SHIFT)
   localparam int unsigned CONTENT_MULT = 3;
   localparam int unsigned CONTENT_BANK_STEP = 85;
   localparam int unsigned CONTENT_HI_SHIFT = 8;
endpackage

// File: rtl/rom_onehot_dec.sv
module rom_onehot_dec #(
   parameter int unsigned IN_W = 2,
   localparam int unsigned OUT_N = 1 << IN_W
) (
   input  logic [IN_W-1:0]  sel,
   output logic [OUT_N-1:0] hot
);
   generate
      if (IN_W < 1) begin : g_bad_width
         $error("rom_onehot_dec: IN_W must be at least 1");
      end
      for (genvar i = 0; i < OUT_N; i++) begin : g_out
         assign hot[i] = (sel == IN_W'(i));
      end
   endgenerate
endmodule

// File: rtl/rom_chip_sel.sv
module rom_chip_sel
   import rom_page_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BANK_AW = 13,
   parameter sel_mode_e   MODE    = SEL_PAIRED,
   localparam int unsigned SEL_W  = ADDR_W - BANK_AW,
   localparam int unsigned NB     = 1 << SEL_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NB-1:0]     cs_n,
   output logic [NB-1:0]     oe_n
);
   generate
      if (MODE == SEL_FULL) begin : g_full
         logic [NB-1:0] hot;
         rom_onehot_dec #(.IN_W(SEL_W)) u_dec (
            .sel (addr[ADDR_W-1:BANK_AW]),
            .hot (hot)
         );
         for (genvar b = 0; b < NB; b++) begin : g_bank
            assign cs_n[b] = ~hot[b];
            assign oe_n[b] = ~hot[b];
         end
      end else begin : g_paired
         if (SEL_W < 2) begin : g_bad_sel
            $error("rom_chip_sel: paired mode needs at least four banks");
         end
         localparam int unsigned GRP_W = SEL_W - 1;
         localparam int unsigned NGRP  = 1 << GRP_W;
         logic [NGRP-1:0] grp_hot;
         logic            half;
         assign half = addr[BANK_AW];
         rom_onehot_dec #(.IN_W(GRP_W)) u_dec (
            .sel (addr[ADDR_W-1:BANK_AW+1]),
            .hot (grp_hot)
         );
         for (genvar b = 0; b < NB; b++) begin : g_bank
            assign cs_n[b] = ~grp_hot[b/2];
            if ((b % 2) == 0) begin : g_even
               assign oe_n[b] = half;
            end else begin : g_odd
               assign oe_n[b] = ~half;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rom_bank_model.sv
module rom_bank_model
   import rom_page_pkg::*;
#(
   parameter int unsigned BANK_ID = 0,
   parameter int unsigned BANK_AW = 13,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned BASE   = BANK_ID * CONTENT_BANK_STEP
) (
   input  logic [BANK_AW-1:0] offset,
   input  logic               cs_n,
   input  logic               oe_n,
   output logic               drive,
   output logic [DATA_W-1:0]  word
);
   logic [31:0] off32;
   assign off32 = 32'(offset);
   assign drive = ~cs_n & ~oe_n;
   assign word  = DATA_W'(off32 * CONTENT_MULT + BASE + (off32 >> CONTENT_HI_SHIFT));
endmodule

// File: rtl/rom_read_mux.sv
module rom_read_mux #(
   parameter int unsigned NB     = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic [NB-1:0]             drive,
   input  logic [NB-1:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0]         rd_data
);
   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NB; b++) begin
         if (drive[b]) rd_data = rd_data | words[b];
      end
   end
endmodule

// File: rtl/rom_page_decode.sv
module rom_page_decode
   import rom_page_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BANK_AW = 13,
   parameter int unsigned DATA_W  = 8,
   parameter sel_mode_e   MODE    = SEL_PAIRED,
   localparam int unsigned SEL_W  = ADDR_W - BANK_AW,
   localparam int unsigned NB     = 1 << SEL_W
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NB-1:0]      cs_n,
   output logic [NB-1:0]      oe_n,
   output logic [BANK_AW-1:0] bank_addr,
   output logic [DATA_W-1:0]  rd_data
);
   generate
      if (BANK_AW >= ADDR_W) begin : g_bad_aw
         $error("rom_page_decode: BANK_AW must be below ADDR_W");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_dw
         $error("rom_page_decode: DATA_W must be 1..32");
      end
   endgenerate

   logic [NB-1:0]             drive;
   logic [NB-1:0][DATA_W-1:0] words;

   assign bank_addr = addr[BANK_AW-1:0];

   rom_chip_sel #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .MODE(MODE)) u_sel (
      .addr (addr),
      .cs_n (cs_n),
      .oe_n (oe_n)
   );

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         rom_bank_model #(.BANK_ID(b), .BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_bank (
            .offset (bank_addr),
            .cs_n   (cs_n[b]),
            .oe_n   (oe_n[b]),
            .drive  (drive[b]),
            .word   (words[b])
         );
      end
   endgenerate

   rom_read_mux #(.NB(NB), .DATA_W(DATA_W)) u_mux (
      .drive   (drive),
      .words   (words),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/rom_page_decode_chk.sv
module rom_page_decode_chk
   import rom_page_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BANK_AW = 13,
   parameter int unsigned DATA_W  = 8,
   parameter sel_mode_e   MODE    = SEL_PAIRED,
   localparam int unsigned SEL_W  = ADDR_W - BANK_AW,
   localparam int unsigned NB     = 1 << SEL_W
) (
   input logic [ADDR_W-1:0]  addr,
   input logic [NB-1:0]      cs_n,
   input logic [NB-1:0]      oe_n,
   input logic [BANK_AW-1:0] bank_addr,
   input logic [DATA_W-1:0]  rd_data
);
   logic [NB-1:0] both_on;
   logic [NB-1:0] want_bank;
   assign both_on   = ~cs_n & ~oe_n;
   assign want_bank = NB'(1) << addr[ADDR_W-1:BANK_AW];

   always_comb begin
      // R1
      offset_pass_chk: assert (bank_addr == addr[BANK_AW-1:0]);
      // R5
      one_driver_chk: assert ($countones(both_on) == 1);
      // R5
      driver_index_chk: assert (both_on == want_bank);
      if (MODE == SEL_PAIRED) begin
         // R2
         pair_select_chk: assert ($countones(~cs_n) == 2);
         // R3
         half_enable_chk: assert ($countones(~oe_n) == NB/2);
      end else begin
         // R4
         single_select_chk: assert ($countones(~cs_n) == 1);
         // R4
         tied_enable_chk: assert (oe_n == cs_n);
      end
   end
endmodule

bind rom_page_decode rom_page_decode_chk #(
   .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .DATA_W(DATA_W), .MODE(MODE)
) u_chk (.*);

// File: tb/tb_rom_page_decode.sv
`timescale 1ns/1ps
module tb_rom_page_decode;
   import rom_page_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  cs_n, oe_n, f_cs_n, f_oe_n, rd_data, f_rd_data;
   logic [12:0] bank_addr, f_bank_addr;
   int          nchk = 0;
   int          nfail = 0;

   always #5 clk = ~clk;

   rom_page_decode #(.MODE(SEL_PAIRED)) dut (
      .addr(addr), .cs_n(cs_n), .oe_n(oe_n), .bank_addr(bank_addr), .rd_data(rd_data)
   );
   rom_page_decode #(.MODE(SEL_FULL)) dut_full (
      .addr(addr), .cs_n(f_cs_n), .oe_n(f_oe_n), .bank_addr(f_bank_addr), .rd_data(f_rd_data)
   );

   function automatic logic [7:0] exp_data(input logic [15:0] a);
      int unsigned off = 32'(a[12:0]);
      int unsigned b = 32'(a[15:13]);
      return 8'((off * 3 + b * 85 + off / 256) % 256);
   endfunction

   function automatic logic [7:0] exp_cs_pair(input logic [15:0] a);
      logic [7:0] r = '1;
      for (int b = 0; b < 8; b++) if (b / 2 == int'(a[15:14])) r[b] = 1'b0;
      return r;
   endfunction

   function automatic logic [7:0] exp_oe_pair(input logic [15:0] a);
      logic [7:0] r;
      for (int b = 0; b < 8; b++) r[b] = (b % 2 == 0) ? a[13] : ~a[13];
      return r;
   endfunction

   function automatic logic [7:0] exp_cs_full(input logic [15:0] a);
      logic [7:0] r = '1;
      r[a[15:13]] = 1'b0;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a);
      logic [7:0] onehot;
      @(posedge clk);
      #1 addr = a;
      @(negedge clk);
      onehot = 8'(1) << a[15:13];
      chk(bank_addr == a[12:0], "R1", 32'(bank_addr), 32'(a[12:0]));
      chk(cs_n == exp_cs_pair(a), "R2", 32'(cs_n), 32'(exp_cs_pair(a)));
      chk(oe_n == exp_oe_pair(a), "R3", 32'(oe_n), 32'(exp_oe_pair(a)));
      chk(f_cs_n == exp_cs_full(a) && f_oe_n == f_cs_n, "R4",
          32'({f_cs_n, f_oe_n}), 32'({exp_cs_full(a), exp_cs_full(a)}));
      chk((~cs_n & ~oe_n) == onehot && (~f_cs_n & ~f_oe_n) == onehot, "R5",
          32'({~cs_n & ~oe_n, ~f_cs_n & ~f_oe_n}), 32'({onehot, onehot}));
      chk(rd_data == exp_data(a), "R6", 32'(rd_data), 32'(exp_data(a)));
      chk(f_rd_data == rd_data, "R7", 32'(f_rd_data), 32'(rd_data));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired addr=%h actual=hung expected=done", addr);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // state after reset with address zero: pair 0 selected, even banks enabled (R2, R3)
      @(negedge clk);
      chk(cs_n == 8'hFC, "R2", 32'(cs_n), 32'hFC);
      chk(oe_n == 8'hAA, "R3", 32'(oe_n), 32'hAA);
      // directed bank and pair edges
      apply(16'h0000);
      apply(16'h1FFF);
      apply(16'h2000);
      apply(16'h3FFF);
      apply(16'h4000);
      apply(16'hBFFF);
      apply(16'hC000);
      apply(16'hDFFF);
      apply(16'hE000);
      apply(16'hFFFF);
      for (int i = 0; i < 2000; i++) apply(16'($urandom));
      // exhaustive sweep over every address (R5, R7)
      for (int a = 0; a < 65536; a++) apply(16'(a));
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule